// File: doc/BRIEF.md
# Byte and Word Load Unit with Split-Access Merging

This block serves loads for a byte-addressed memory that is organised as 4-byte words and can only return whole aligned words. A request carries a byte address, an opcode choosing a single byte or a full word, and a bit that asks for sign extension of byte results. The unit turns each request into one or two aligned word reads on a synchronous memory port. It then steers or merges the returned bytes into a 32-bit little-endian result, which it hands back on a response interface.

A byte load, or a word load whose address is a multiple of four, needs a single read. A word load that straddles two words reads the word at or below the address, then the next word. It keeps the first word in a holding register and takes the tail from the second. When the strict input is high at acceptance, such a straddling word load is refused without touching memory and returns an error response. Byte loads are never refused.

Requests and responses use valid/ready handshakes. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so exactly one load is in flight at a time. A response is presented with `rsp_valid` and held unchanged until the edge where `rsp_ready` is high. The consumer may hold `rsp_ready` low for any number of cycles.

Top module: `load_align_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: Every memory read has `mem_rd_addr[1:0]` equal to 0.
- R3: A byte load (`req_op`=0) at address A issues exactly one read, at A with its low two bits cleared. It returns byte A, taken from bits 8*A[1:0]+7 down to 8*A[1:0] of the read word, in bits 7:0. It is never refused, even in strict mode.
- R4: With `req_sext`=0 a byte result has bits 31:8 zero. With `req_sext`=1 those bits copy bit 7. `req_sext` has no effect on word loads.
- R5: A word load (`req_op`=1) with A[1:0]=0 issues one read at A and returns bytes A..A+3, with the byte at A in bits 7:0. `rsp_valid` rises in the third cycle after acceptance.
- R6: A word load with A[1:0]≠0 and strict low issues two reads in consecutive cycles: first the aligned word below A, then that address plus 4 (wrapping modulo 2^32). It returns bytes A..A+3 little-endian, and `rsp_valid` rises in the fourth cycle after acceptance.
- R7: A word load with A[1:0]≠0 and `strict`=1 at acceptance issues no read. It responds in the first cycle after acceptance with `rsp_err`=1 and `rsp_data`=0.
- R8: From acceptance until the edge at which the response is taken, `req_ready` is 0. No read is issued while `req_ready` is 1.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_data` and `rsp_err` keep their values on the next cycle.
- R10: Every response not refused under R7 has `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strict | input | 1 | When high at acceptance, a straddling word load is refused |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 1 | 0 = byte load, 1 = word load |
| req_sext | input | 1 | Sign-extend a byte result |
| req_addr | input | 32 | Byte address of the load |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Word-aligned byte address of the read |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Load result |
| rsp_err | output | 1 | Load refused as misaligned |

## Verification
The assertions assume that the memory returns data exactly one cycle after each strobe. They also assume `strict`, `req_op`, `req_sext` and `req_addr` matter only in the cycle a request is accepted. The bench meets this with a memory model that answers on the clock edge following `mem_rd_en`, and it changes request fields only while `req_valid` is driven. It never raises `req_valid` while a load is still in flight, and it holds `rsp_ready` low for chosen stretches so that the response-hold property is exercised.

// File: rtl/lau_pkg.sv
package lau_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_FIRST,
    ST_SECOND,
    ST_RESP
  } lau_state_e;

  localparam logic OP_BYTE = 1'b0;
  localparam logic OP_WORD = 1'b1;

endpackage

// File: rtl/lau_addr_split.sv
module lau_addr_split #(
  parameter int ADDR_W = 32,
  parameter int BYTES  = 4,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] next,
  output logic [OFF_W-1:0]  offset,
  output logic              unaligned
);

  always_comb begin
    base      = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    next      = base + ADDR_W'(BYTES);
    offset    = addr[OFF_W-1:0];
    unaligned = |addr[OFF_W-1:0];
  end

endmodule

// File: rtl/lau_steer.sv
module lau_steer #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] word0,
  input  logic [DATA_W-1:0] word1,
  input  logic [OFF_W-1:0]  offset,
  input  logic              is_word,
  input  logic              sext,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] merged;

  // each output lane picks byte (offset + lane) from the pair of words
  for (genvar lane = 0; lane < BYTES; lane++) begin : g_lane
    logic [OFF_W:0] src;
    always_comb begin
      src = {1'b0, offset} + (OFF_W + 1)'(lane);
      if (src[OFF_W])
        merged[lane*8 +: 8] = word1[src[OFF_W-1:0]*8 +: 8];
      else
        merged[lane*8 +: 8] = word0[src[OFF_W-1:0]*8 +: 8];
    end
  end

  always_comb begin
    if (is_word)
      result = merged;
    else
      result = {{(DATA_W-8){sext & merged[7]}}, merged[7:0]};
  end

endmodule

// File: rtl/lau_ctrl.sv
module lau_ctrl
  import lau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_is_word,
  input  logic req_unaligned,
  input  logic strict,
  input  logic split,
  input  logic rsp_ready,
  output logic req_ready,
  output logic accept,
  output logic reject,
  output logic rd_en,
  output logic rd_next,
  output logic cap_hold,
  output logic cap_result,
  output logic second_phase,
  output logic rsp_valid
);

  lau_state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    req_ready    = 1'b0;
    accept       = 1'b0;
    reject       = 1'b0;
    rd_en        = 1'b0;
    rd_next      = 1'b0;
    cap_hold     = 1'b0;
    cap_result   = 1'b0;
    second_phase = 1'b0;
    rsp_valid    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          accept = 1'b1;
          reject = req_is_word & req_unaligned & strict;
          state_d = reject ? ST_RESP : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        rd_en   = 1'b1;
        state_d = ST_FIRST;
      end
      ST_FIRST: begin
        if (split) begin
          cap_hold = 1'b1;
          rd_en    = 1'b1;
          rd_next  = 1'b1;
          state_d  = ST_SECOND;
        end else begin
          cap_result = 1'b1;
          state_d    = ST_RESP;
        end
      end
      ST_SECOND: begin
        second_phase = 1'b1;
        cap_result   = 1'b1;
        state_d      = ST_RESP;
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/load_align_unit.sv
module load_align_unit
  import lau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strict,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_sext,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_err
);

  logic              lat_word_q, lat_sext_q;
  logic [ADDR_W-1:0] lat_addr_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] data_q;
  logic              err_q;

  logic [ADDR_W-1:0] base_addr, next_addr;
  logic [OFF_W-1:0]  lat_off;
  logic              lat_unaligned;
  logic              req_unaligned;
  logic              split;
  logic              accept, reject, rd_next, cap_hold, cap_result, second_phase;
  logic [DATA_W-1:0] steer_w0, steer_out;

  assign req_unaligned = |req_addr[OFF_W-1:0];
  assign split         = lat_word_q & lat_unaligned;

  lau_addr_split #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_split (
    .addr      (lat_addr_q),
    .base      (base_addr),
    .next      (next_addr),
    .offset    (lat_off),
    .unaligned (lat_unaligned)
  );

  lau_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_is_word   (req_op == OP_WORD),
    .req_unaligned (req_unaligned),
    .strict        (strict),
    .split         (split),
    .rsp_ready     (rsp_ready),
    .req_ready     (req_ready),
    .accept        (accept),
    .reject        (reject),
    .rd_en         (mem_rd_en),
    .rd_next       (rd_next),
    .cap_hold      (cap_hold),
    .cap_result    (cap_result),
    .second_phase  (second_phase),
    .rsp_valid     (rsp_valid)
  );

  assign mem_rd_addr = rd_next ? next_addr : base_addr;
  assign steer_w0    = second_phase ? hold_q : mem_rd_data;

  lau_steer #(.DATA_W(DATA_W)) u_steer (
    .word0   (steer_w0),
    .word1   (mem_rd_data),
    .offset  (lat_off),
    .is_word (lat_word_q),
    .sext    (lat_sext_q),
    .result  (steer_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_word_q <= 1'b0;
      lat_sext_q <= 1'b0;
      lat_addr_q <= '0;
    end else if (accept) begin
      lat_word_q <= (req_op == OP_WORD);
      lat_sext_q <= req_sext;
      lat_addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (cap_hold) hold_q <= mem_rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      err_q  <= 1'b0;
    end else if (reject) begin
      data_q <= '0;
      err_q  <= 1'b1;
    end else if (cap_result) begin
      data_q <= steer_out;
      err_q  <= 1'b0;
    end
  end

  assign rsp_data = data_q;
  assign rsp_err  = err_q;

endmodule

// File: rtl/lau_checker.sv
module lau_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int OFF_W = $clog2(BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_err
);

  AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> mem_rd_addr[OFF_W-1:0] == '0); // R2

  AST_SECOND_READ_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && $past(mem_rd_en) |-> mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(BYTES)); // R6

  AST_REFUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> rsp_data == '0); // R7

  AST_NO_READ_AT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_rd_en); // R7

  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R8

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en); // R8

  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err)); // R9

endmodule

bind load_align_unit lau_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_lau_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .rsp_err     (rsp_err)
);

// File: tb/load_align_unit_test.sv
`timescale 1ns/1ps
module load_align_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strict = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic        req_sext = 1'b0;
  logic [31:0] req_addr = '0;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int n_chk = 0;
  int n_err = 0;
  logic [31:0] rd_log[$];

  always #2 clk = ~clk;

  load_align_unit uut (
    .clk(clk), .rst_n(rst_n), .strict(strict),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_sext(req_sext), .req_addr(req_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return (a[7:0] * 8'd37) ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {mbyte(a + 32'd3), mbyte(a + 32'd2), mbyte(a + 32'd1), mbyte(a)};
  endfunction

  // memory model: one-cycle read latency, logs every read address
  always @(posedge clk) begin
    if (rst_n && mem_rd_en) begin
      mem_rd_data <= word_at(mem_rd_addr);
      rd_log.push_back(mem_rd_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_load(input bit word, input bit sext, input logic [31:0] addr,
                         input bit strict_m, input int hold, input string tag);
    bit          rej, spl;
    int          lat, reads;
    logic [7:0]  b;
    logic [31:0] exp_d, base;
    rej   = word && addr[1:0] != 2'b00 && strict_m;
    spl   = word && addr[1:0] != 2'b00 && !strict_m;
    lat   = rej ? 1 : (spl ? 4 : 3);
    reads = rej ? 0 : (spl ? 2 : 1);
    b     = mbyte(addr);
    base  = {addr[31:2], 2'b00};
    if (rej)       exp_d = '0;
    else if (word) exp_d = word_at(addr);
    else           exp_d = {{24{sext & b[7]}}, b};

    @(negedge clk);
    chk(req_ready === 1'b1, "R8 ready before request", {31'd0, req_ready}, 32'd1);
    rd_log.delete();
    strict = strict_m; req_op = word; req_sext = sext; req_addr = addr; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 1; c < lat; c++) begin
      chk(rsp_valid === 1'b0, "R5 R6 response not early", {31'd0, rsp_valid}, 32'd0);
      chk(req_ready === 1'b0, "R8 busy", {31'd0, req_ready}, 32'd0);
      @(negedge clk);
    end
    chk(rsp_valid === 1'b1, rej ? "R7 response timing" : (spl ? "R6 response timing" : "R5 response timing"),
        {31'd0, rsp_valid}, 32'd1);
    chk(rsp_data === exp_d, tag, rsp_data, exp_d);
    chk(rsp_err === rej, rej ? "R7 error flag" : "R10 no error", {31'd0, rsp_err}, {31'd0, rej});
    chk(req_ready === 1'b0, "R8 busy while responding", {31'd0, req_ready}, 32'd0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_data === exp_d && rsp_err === rej, "R9 held response",
          rsp_data, exp_d);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R8 idle after take",
        {30'd0, rsp_valid, req_ready}, 32'd1);
    chk(rd_log.size() == reads, rej ? "R7 no read" : (spl ? "R6 read count" : "R3 R5 read count"),
        rd_log.size(), reads);
    if (rd_log.size() >= 1 && reads >= 1)
      chk(rd_log[0] === base, "R2 R3 first read address", rd_log[0], base);
    if (rd_log.size() >= 2 && reads == 2)
      chk(rd_log[1] === base + 32'd4, "R6 second read address", rd_log[1], base + 32'd4);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_en === 1'b0, "R1 reset state",
        {29'd0, req_ready, rsp_valid, mem_rd_en}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mem_rd_en === 1'b0, "R1 after release",
        {29'd0, req_ready, rsp_valid, mem_rd_en}, 32'd4);

    for (int o = 0; o < 4; o++) begin
      do_load(1'b0, 1'b0, 32'h0000_0010 + 32'(o), 1'b0, 0, "R3 byte zero-extended");
      do_load(1'b0, 1'b1, 32'h0000_0010 + 32'(o), 1'b0, 0, "R4 byte sign-extended");
    end
    do_load(1'b0, 1'b1, 32'h0000_0022, 1'b0, 0, "R4 byte sign-extended");
    do_load(1'b0, 1'b0, 32'h0000_0013, 1'b1, 0, "R3 byte in strict mode");
    do_load(1'b1, 1'b0, 32'h0000_0010, 1'b0, 0, "R5 aligned word");
    do_load(1'b1, 1'b1, 32'h0000_0044, 1'b0, 2, "R4 sext ignored on word");
    do_load(1'b1, 1'b0, 32'h0000_0020, 1'b1, 0, "R5 aligned word in strict mode");
    for (int o = 1; o < 4; o++)
      do_load(1'b1, 1'b0, 32'h0000_0010 + 32'(o), 1'b0, o, "R6 merged word");
    do_load(1'b1, 1'b0, 32'hFFFF_FFFE, 1'b0, 0, "R6 merged word across wrap");
    for (int o = 1; o < 4; o++)
      do_load(1'b1, 1'b0, 32'h0000_0030 + 32'(o), 1'b1, 1, "R7 refused data");
    do_load(1'b1, 1'b0, 32'h0000_0011, 1'b0, 0, "R6 merged after refusal");
    for (int k = 0; k < 24; k++)
      do_load(k % 3 != 0, k % 2 == 1, 32'h0000_1000 + 32'(k * 13), k % 5 == 0, k % 3,
              "R6 R3 mixed pattern");
    finish_run();
  end

endmodule